// File: doc/BRIEF.md
# USB Endpoint Bank Auto-Validation Controller

This block keeps the ping-pong buffer banks of one non-control USB device endpoint. Each bank has a ready flag. For an IN endpoint the flag means "packet loaded, waiting for the host". For an OUT endpoint it means "packet received, waiting to be read". A one-hot-free bank pointer names the bank that the local side (CPU or DMA) is working on.

When auto-validation is on, the block hands a bank over by itself. An IN bank is validated when it fills or when its DMA buffer ends. An OUT bank is released when its last byte is read or when its DMA buffer ends. After the hand-over the pointer moves to the next bank. Firmware can still validate or release the current bank with single-cycle pulses at any time.

The block also produces the endpoint's DMA request. An endpoint interrupt can suppress that request in one of two ways, depending on whether the interrupt belongs to a new bank packet.

Top module: `usb_bank_autoval`

## Requirements
- R1: After reset every bank ready flag is 0 and the current bank index is 0. The DMA request is then active exactly when the endpoint is enabled and the current bank's flag is 0 for IN (`dir_in`=1) or 1 for OUT (`dir_in`=0).
- R2: While the endpoint is disabled, the flags, the bank index and the interrupt gating state do not change, and the DMA request is 0.
- R3: IN with auto-validation on: a `bank_full` pulse on a current bank whose flag is 0 sets that flag and advances the index by one, wrapping after the last bank.
- R4: IN with auto-validation on: a `dma_end` pulse validates and advances like R3 only while `dma_end_en` is 1. With `dma_end_en` at 0 the pulse has no effect.
- R5: IN: a `fw_set` pulse validates the current bank and advances, whatever the auto-validation setting and whatever the bank's fill level. This includes an empty bank, which gives a zero-length packet.
- R6: OUT with auto-validation on: a `last_rd` pulse, or a `dma_end` pulse with `dma_end_en` at 1, clears the flag of a current bank whose flag is 1 and advances the index.
- R7: OUT: a `fw_clr` pulse clears the current bank's flag and advances, whatever the auto-validation setting.
- R8: With `is_ctrl` at 1 the auto-validation bit is ignored. Only firmware pulses hand banks over.
- R9: A hand-over request whose current bank flag is already in the target state (1 for IN, 0 for OUT) changes neither the flag nor the index.
- R10: A `bus_done` pulse clears the flag of bank `bus_bank` for IN and sets it for OUT. `busy_cnt` always equals the number of flags at 1.
- R11: With `irq_gates_dma` at 1, an `irq_fire` with `irq_newbank` at 1 lets the DMA request stay up while `dma_active` is 1. Once `dma_active` is 0 the request is held at 0, until `irq_src_clr` pulses or `irq_gates_dma` is 0 at a clock edge.
- R12: With `irq_gates_dma` at 1, an `irq_fire` with `irq_newbank` at 0 forces the DMA request to 0 from the next cycle, even while `dma_active` is 1. The release condition is the same as in R11.
- R13: When a firmware pulse and an automatic event hit the current bank in the same cycle, the firmware command is the one applied. The index advances by one only.
- R14: With parameter `EP_INDEX` at 0 the endpoint is enabled regardless of `ep_en`, starting from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ep_en | input | 1 | Endpoint enable (ignored when EP_INDEX is 0) |
| auto_val | input | 1 | Auto-validation on |
| irq_gates_dma | input | 1 | Endpoint interrupt suppresses the DMA request |
| is_ctrl | input | 1 | Endpoint is control type |
| dir_in | input | 1 | 1 = IN, 0 = OUT |
| bank_full | input | 1 | Current IN bank became full |
| last_rd | input | 1 | Last byte of current OUT bank read |
| dma_end | input | 1 | End of DMA buffer |
| dma_end_en | input | 1 | End-of-buffer hand-over enable |
| fw_set | input | 1 | Firmware validates current IN bank |
| fw_clr | input | 1 | Firmware releases current OUT bank |
| bus_done | input | 1 | Bus side finished a packet on `bus_bank` |
| bus_bank | input | PTR_W | Bank used by the bus side |
| irq_fire | input | 1 | Enabled endpoint interrupt event |
| irq_newbank | input | 1 | Event belongs to a new bank packet |
| irq_src_clr | input | 1 | Firmware cleared the interrupt source |
| dma_active | input | 1 | A DMA transfer is in progress |
| bank_rdy | output | NUM_BANKS | Per-bank ready flags |
| cur_bank | output | PTR_W | Current local-side bank |
| busy_cnt | output | CNT_W | Number of flags at 1 |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds two instances with two banks each. One uses `EP_INDEX`=1, so `ep_en` is live and the disabled-endpoint behaviour is reachable. The other uses `EP_INDEX`=0 with `ep_en` tied low, which shows the forced enable. Two banks make the wrap of the index and the blocked hand-over occur within a few pulses. A long stretch of mixed stimulus then lands firmware and automatic events on the same bank in one cycle.

// File: rtl/usb_bank_pkg.sv
// Package: shared types for the endpoint bank controller.
// Assumes: nothing beyond IEEE 1800-2017.
package usb_bank_pkg;

    // Source of a hand-over request for the current bank.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_AUTO = 2'd1,
        SRC_FW   = 2'd2
    } handover_src_e;

    // Request to flip the current bank to its target state.
    typedef struct packed {
        logic          req;
        handover_src_e src;
    } handover_t;

endpackage

// File: rtl/bank_event_arb.sv
// Module: bank_event_arb
// Merges automatic and firmware hand-over events into one request per cycle.
// A firmware command wins over an automatic event in the same cycle.
// Assumes: all event inputs are single-cycle pulses. Control endpoints
// never auto-validate.
module bank_event_arb
    import usb_bank_pkg::*;
(
    input  logic      auto_val,
    input  logic      is_ctrl,
    input  logic      dir_in,
    input  logic      bank_full,
    input  logic      last_rd,
    input  logic      dma_end,
    input  logic      dma_end_en,
    input  logic      fw_set,
    input  logic      fw_clr,
    output handover_t hov
);
    logic auto_on;
    logic auto_evt;
    logic fw_evt;

    // Qualify the automatic and firmware events for the current direction.
    always_comb begin
        auto_on  = auto_val && !is_ctrl;
        auto_evt = auto_on && ((dir_in ? bank_full : last_rd) || (dma_end && dma_end_en));
        fw_evt   = dir_in ? fw_set : fw_clr;
    end

    // Pick the winning source: firmware first.
    always_comb begin
        hov.req = fw_evt || auto_evt;
        if (fw_evt)
            hov.src = SRC_FW;
        else if (auto_evt)
            hov.src = SRC_AUTO;
        else
            hov.src = SRC_NONE;
    end
endmodule

// File: rtl/bank_ring.sv
// Module: bank_ring
// Holds the per-bank ready flags and the current local-side bank pointer.
// A granted hand-over drives the current flag to its target state
// (1 for IN, 0 for OUT) and moves the pointer on, wrapping.
// Assumes: bus completions and local hand-overs never target the same flag
// value in one cycle (they need opposite starting states).
module bank_ring #(
    parameter int NB    = 2,
    parameter int PTR_W = (NB > 1) ? $clog2(NB) : 1,
    parameter int CNT_W = $clog2(NB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_in,
    input  logic             hov_req,
    input  logic             bus_done,
    input  logic [PTR_W-1:0] bus_bank,
    output logic [NB-1:0]    flags,
    output logic [PTR_W-1:0] cur,
    output logic [CNT_W-1:0] busy
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NB - 1);

    logic grant;
    logic cur_flag;

    // A request is granted only if the current bank is not already in target state.
    always_comb begin
        cur_flag = flags[cur];
        grant    = en && hov_req && (cur_flag ^ dir_in);
    end

    // Per-bank ready flag.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[b] <= 1'b0;
            else if (grant && (cur == PTR_W'(b)))
                flags[b] <= dir_in;
            else if (en && bus_done && (bus_bank == PTR_W'(b)))
                flags[b] <= !dir_in;
        end
    end

    // Local-side pointer advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (grant)
            cur <= (cur == LAST) ? '0 : cur + 1'b1;
    end

    // Count of banks holding a ready flag.
    always_comb begin
        busy = '0;
        for (int i = 0; i < NB; i++)
            busy = busy + CNT_W'(flags[i]);
    end
endmodule

// File: rtl/dma_gate.sv
// Module: dma_gate
// Suppresses the DMA request after an endpoint interrupt. An interrupt tied to
// a new bank packet lets a running transfer finish. Any other interrupt drops
// the request at once. Both holds end on a source clear or when gating is off.
// Assumes: dma_active stays high until the running transfer completes.
module dma_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic gates,
    input  logic irq_fire,
    input  logic irq_newbank,
    input  logic src_clr,
    input  logic dma_active,
    input  logic want,
    output logic req
);
    logic hold_soft;
    logic hold_hard;

    // Track the two suppression modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_soft <= 1'b0;
            hold_hard <= 1'b0;
        end else if (en) begin
            if (!gates || src_clr) begin
                hold_soft <= 1'b0;
                hold_hard <= 1'b0;
            end else if (irq_fire) begin
                if (irq_newbank)
                    hold_soft <= 1'b1;
                else
                    hold_hard <= 1'b1;
            end
        end
    end

    // Final request: soft hold lets an active transfer run on.
    always_comb begin
        req = en && want && !hold_hard && !(hold_soft && !dma_active);
    end
endmodule

// File: rtl/usb_bank_autoval.sv
// Module: usb_bank_autoval (top)
// Bank hand-over and DMA request control for one non-control USB endpoint.
// Assumes: event inputs are single-cycle pulses synchronous to clk.
// EP_INDEX 0 forces the endpoint enabled.
module usb_bank_autoval
    import usb_bank_pkg::*;
#(
    parameter int EP_INDEX  = 1,
    parameter int NUM_BANKS = 2,
    parameter int PTR_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int CNT_W     = $clog2(NUM_BANKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ep_en,
    input  logic                 auto_val,
    input  logic                 irq_gates_dma,
    input  logic                 is_ctrl,
    input  logic                 dir_in,
    input  logic                 bank_full,
    input  logic                 last_rd,
    input  logic                 dma_end,
    input  logic                 dma_end_en,
    input  logic                 fw_set,
    input  logic                 fw_clr,
    input  logic                 bus_done,
    input  logic [PTR_W-1:0]     bus_bank,
    input  logic                 irq_fire,
    input  logic                 irq_newbank,
    input  logic                 irq_src_clr,
    input  logic                 dma_active,
    output logic [NUM_BANKS-1:0] bank_rdy,
    output logic [PTR_W-1:0]     cur_bank,
    output logic [CNT_W-1:0]     busy_cnt,
    output logic                 dma_req
);
    logic      en_eff;
    logic      dma_want;
    handover_t hov;

    // Endpoint 0 is always live; others follow the enable input.
    if (EP_INDEX == 0) begin : g_ep0
        assign en_eff = 1'b1;
    end else begin : g_epn
        assign en_eff = ep_en;
    end

    bank_event_arb u_arb (
        .auto_val   (auto_val),
        .is_ctrl    (is_ctrl),
        .dir_in     (dir_in),
        .bank_full  (bank_full),
        .last_rd    (last_rd),
        .dma_end    (dma_end),
        .dma_end_en (dma_end_en),
        .fw_set     (fw_set),
        .fw_clr     (fw_clr),
        .hov        (hov)
    );

    bank_ring #(.NB(NUM_BANKS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_eff),
        .dir_in   (dir_in),
        .hov_req  (hov.req),
        .bus_done (bus_done),
        .bus_bank (bus_bank),
        .flags    (bank_rdy),
        .cur      (cur_bank),
        .busy     (busy_cnt)
    );

    // DMA wants a free IN bank or a filled OUT bank.
    always_comb begin
        dma_want = dir_in ? !bank_rdy[cur_bank] : bank_rdy[cur_bank];
    end

    dma_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en_eff),
        .gates       (irq_gates_dma),
        .irq_fire    (irq_fire),
        .irq_newbank (irq_newbank),
        .src_clr     (irq_src_clr),
        .dma_active  (dma_active),
        .want        (dma_want),
        .req         (dma_req)
    );
endmodule

// File: rtl/usb_bank_autoval_chk.sv
// Module: usb_bank_autoval_chk
// Assertion checker bound to usb_bank_autoval; observes ports only.
module usb_bank_autoval_chk #(
    parameter int EP_INDEX  = 1,
    parameter int NUM_BANKS = 2,
    parameter int PTR_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ep_en,
    input logic                 auto_val,
    input logic                 irq_gates_dma,
    input logic                 is_ctrl,
    input logic                 dir_in,
    input logic                 bank_full,
    input logic                 irq_fire,
    input logic                 irq_newbank,
    input logic                 irq_src_clr,
    input logic [NUM_BANKS-1:0] bank_rdy,
    input logic [PTR_W-1:0]     cur_bank,
    input logic                 dma_req
);
    localparam bit CAN_DISABLE = (EP_INDEX != 0);

    logic live;

    // Effective enable as seen from the ports.
    always_comb live = !CAN_DISABLE || ep_en;

    // R1: state is clear on the first cycle out of reset.
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (bank_rdy == '0 && cur_bank == '0));

    // R2: a disabled endpoint holds its banks.
    a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> ($stable(bank_rdy) && $stable(cur_bank)));

    // R2: no DMA request while disabled.
    a_r2_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> !dma_req);

    // R3: an automatic fill on a free IN bank moves the pointer.
    a_r3_auto_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (live && dir_in && auto_val && !is_ctrl && bank_full && !bank_rdy[cur_bank])
        |=> (cur_bank != $past(cur_bank)));

    // R9: a ready IN bank never lets the pointer move.
    a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in && bank_rdy[cur_bank]) |=> $stable(cur_bank));

    // R12: a non-bank interrupt kills the request next cycle.
    a_r12_hard_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (live && irq_gates_dma && irq_fire && !irq_newbank && !irq_src_clr)
        |=> !dma_req);
endmodule

bind usb_bank_autoval usb_bank_autoval_chk #(
    .EP_INDEX(EP_INDEX), .NUM_BANKS(NUM_BANKS), .PTR_W(PTR_W)
) u_chk (.*);

// File: tb/usb_bank_autoval_tb.sv
// Bench for usb_bank_autoval: behavioural reference model compared every cycle.
module usb_bank_autoval_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ep_en = 0, auto_val = 0, irq_gates_dma = 0, is_ctrl = 0, dir_in = 1;
    logic bank_full = 0, last_rd = 0, dma_end = 0, dma_end_en = 0;
    logic fw_set = 0, fw_clr = 0, bus_done = 0, bus_bank = 0;
    logic irq_fire = 0, irq_newbank = 0, irq_src_clr = 0, dma_active = 0;

    logic [1:0] rdy_a, rdy_b;
    logic       cur_a, cur_b, req_a, req_b;
    logic [1:0] cnt_a, cnt_b;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string phase = "R1";

    // Reference model state, index 0 = main instance, 1 = endpoint-0 instance.
    int mrdy [2][2];
    int mcur [2];
    bit mhard[2];
    bit msoft[2];

    always #2 clk = ~clk;

    usb_bank_autoval #(.EP_INDEX(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ep_en(ep_en), .auto_val(auto_val),
        .irq_gates_dma(irq_gates_dma), .is_ctrl(is_ctrl), .dir_in(dir_in),
        .bank_full(bank_full), .last_rd(last_rd), .dma_end(dma_end),
        .dma_end_en(dma_end_en), .fw_set(fw_set), .fw_clr(fw_clr),
        .bus_done(bus_done), .bus_bank(bus_bank), .irq_fire(irq_fire),
        .irq_newbank(irq_newbank), .irq_src_clr(irq_src_clr),
        .dma_active(dma_active), .bank_rdy(rdy_a), .cur_bank(cur_a),
        .busy_cnt(cnt_a), .dma_req(req_a));

    usb_bank_autoval #(.EP_INDEX(0)) u_dut0 (
        .clk(clk), .rst_n(rst_n), .ep_en(1'b0), .auto_val(auto_val),
        .irq_gates_dma(irq_gates_dma), .is_ctrl(is_ctrl), .dir_in(dir_in),
        .bank_full(bank_full), .last_rd(last_rd), .dma_end(dma_end),
        .dma_end_en(dma_end_en), .fw_set(fw_set), .fw_clr(fw_clr),
        .bus_done(bus_done), .bus_bank(bus_bank), .irq_fire(irq_fire),
        .irq_newbank(irq_newbank), .irq_src_clr(irq_src_clr),
        .dma_active(dma_active), .bank_rdy(rdy_b), .cur_bank(cur_b),
        .busy_cnt(cnt_b), .dma_req(req_b));

    // Reference model update at each rising edge, written from the requirements.
    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            bit en, act, tgt;
            int old0, old1;
            en = (m == 1) ? 1'b1 : ep_en;
            if (!rst_n) begin
                mrdy[m][0] = 0; mrdy[m][1] = 0; mcur[m] = 0;
                mhard[m] = 0; msoft[m] = 0;
            end else if (en) begin
                old0 = mrdy[m][0]; old1 = mrdy[m][1];
                tgt = dir_in;
                if (dir_in)
                    act = fw_set || (auto_val && !is_ctrl && (bank_full || (dma_end && dma_end_en)));
                else
                    act = fw_clr || (auto_val && !is_ctrl && (last_rd || (dma_end && dma_end_en)));
                if (bus_done) mrdy[m][bus_bank] = dir_in ? 0 : 1;
                if (act && (((mcur[m] == 0) ? old0 : old1) != int'(tgt))) begin
                    mrdy[m][mcur[m]] = int'(tgt);
                    mcur[m] = (mcur[m] + 1) % 2;
                end
                if (!irq_gates_dma || irq_src_clr) begin
                    mhard[m] = 0; msoft[m] = 0;
                end else if (irq_fire) begin
                    if (irq_newbank) msoft[m] = 1; else mhard[m] = 1;
                end
            end
        end
    end

    function automatic bit exp_req(int m);
        bit en, want;
        en = (m == 1) ? 1'b1 : ep_en;
        want = dir_in ? (mrdy[m][mcur[m]] == 0) : (mrdy[m][mcur[m]] == 1);
        return en && want && !mhard[m] && !(msoft[m] && !dma_active);
    endfunction

    task automatic cmp(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare outputs midway between the driving edge and the next rising edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            cmp(phase, rdy_a, mrdy[0][1] * 2 + mrdy[0][0], "bank_rdy");
            cmp(phase, cur_a, mcur[0], "cur_bank");
            cmp("R10", cnt_a, mrdy[0][0] + mrdy[0][1], "busy_cnt");
            cmp(phase, req_a, exp_req(0), "dma_req");
            cmp("R14", rdy_b, mrdy[1][1] * 2 + mrdy[1][0], "ep0 bank_rdy");
            cmp("R14", cur_b, mcur[1], "ep0 cur_bank");
            cmp("R14", req_b, exp_req(1), "ep0 dma_req");
        end else begin
            cmp("R1", rdy_a, 0, "reset bank_rdy");
            cmp("R1", cur_a, 0, "reset cur_bank");
        end
    end

    // One cycle: inputs held until next falling edge, then pulses drop.
    task automatic tick();
        @(negedge clk);
        bank_full = 0; last_rd = 0; dma_end = 0; fw_set = 0; fw_clr = 0;
        bus_done = 0; irq_fire = 0; irq_src_clr = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1; ep_en = 1; dir_in = 1;
        tick();
        // R3: automatic fill hand-over, then R9 block on third fill.
        phase = "R3"; auto_val = 1;
        bank_full = 1; tick();
        bank_full = 1; tick();
        phase = "R9"; bank_full = 1; tick(); fw_set = 1; tick();
        // R10: bus side drains both banks.
        phase = "R10"; bus_done = 1; bus_bank = 0; tick();
        bus_done = 1; bus_bank = 1; tick();
        // R4: end-of-buffer with and without enable.
        phase = "R4"; dma_end = 1; dma_end_en = 0; tick();
        dma_end = 1; dma_end_en = 1; tick();
        // R5: firmware zero-length validation with auto off.
        phase = "R5"; auto_val = 0; fw_set = 1; tick();
        bus_done = 1; bus_bank = 0; tick(); bus_done = 1; bus_bank = 1; tick();
        // R13: firmware and automatic event together.
        phase = "R13"; auto_val = 1; fw_set = 1; bank_full = 1; tick();
        bus_done = 1; bus_bank = 0; tick(); bus_done = 1; bus_bank = 1; tick();
        // R6: OUT release after bus fills.
        phase = "R6"; dir_in = 0;
        bus_done = 1; bus_bank = 0; tick(); bus_done = 1; bus_bank = 1; tick();
        last_rd = 1; tick(); dma_end = 1; dma_end_en = 1; tick();
        // R7: firmware release with auto off.
        phase = "R7"; auto_val = 0;
        bus_done = 1; bus_bank = 0; tick(); fw_clr = 1; tick();
        // R8: control type ignores auto-validation.
        phase = "R8"; auto_val = 1; is_ctrl = 1;
        bus_done = 1; bus_bank = 1; tick(); last_rd = 1; tick(); tick();
        is_ctrl = 0; last_rd = 1; tick();
        // R2: disabled endpoint ignores everything.
        phase = "R2"; ep_en = 0; bus_done = 1; bus_bank = 0; tick();
        fw_clr = 1; tick(); last_rd = 1; tick(); ep_en = 1; tick();
        bus_done = 1; bus_bank = 0; tick();
        // R11: new-bank interrupt lets a running transfer finish.
        phase = "R11"; irq_gates_dma = 1; dma_active = 1;
        irq_fire = 1; irq_newbank = 1; tick(); tick(); tick();
        dma_active = 0; tick(); tick();
        irq_src_clr = 1; tick(); tick();
        // R12: other interrupt drops the request mid-transfer.
        phase = "R12"; dma_active = 1; irq_fire = 1; irq_newbank = 0; tick(); tick();
        irq_gates_dma = 0; tick(); tick();
        // Mixed stimulus; same-cycle collisions of firmware and automatic events.
        phase = "R13";
        for (int i = 0; i < 3000; i++) begin
            ep_en = ($urandom % 8) != 0; auto_val = $urandom; irq_gates_dma = $urandom;
            is_ctrl = ($urandom % 4) == 0; dir_in = ((i / 200) % 2) == 0;
            bank_full = $urandom; last_rd = $urandom; dma_end = $urandom;
            dma_end_en = $urandom; fw_set = ($urandom % 4) == 0; fw_clr = ($urandom % 4) == 0;
            bus_done = $urandom; bus_bank = $urandom; irq_fire = ($urandom % 6) == 0;
            irq_newbank = $urandom; irq_src_clr = ($urandom % 10) == 0; dma_active = $urandom;
            tick();
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule